// File: doc/BRIEF.md
# Channel Enable Vectors with Atomic Set/Clear Commands

This block holds two 64-bit per-channel enable vectors for a DMA controller: one gates the channels' transfer requests, the other gates their error interrupts. Both vectors drive registered outputs. The channel arbiter uses the request enables and the interrupt logic uses the error enables.

Software can read each vector as two 32-bit words and can replace a whole word with one full-word write. The usual way to change enables is through four byte-wide command registers, which need no read-modify-write. A command byte carries a channel number in bits 5:0 and an "all channels" flag in bit 6. There is a set command and a clear command for each vector.

The bus is a simple one-cycle interface with byte addresses, four byte enables and 32-bit data. Read data is registered.

Top module: `chen_top`

## Requirements
- R1: After reset deassertion, `req_en_o`, `err_en_o` and `bus_rdata_o` are all zero.
- R2: A write to a set command byte with bit 6 clear sets the enable bit selected by bits 5:0 in the target vector and leaves the other 63 bits unchanged. The set-request command is byte 0x1A and the set-error-interrupt command is byte 0x19.
- R3: A write to a clear command byte with bit 6 clear clears the selected enable bit and leaves the other bits unchanged. The clear-request command is byte 0x18 and the clear-error-interrupt command is byte 0x1B.
- R4: A command byte with bit 6 set (any value from 64 to 127) acts on all 64 bits of its target vector. A set command sets all of them and a clear command clears all of them.
- R5: Bit 7 of a command byte is ignored. For example, 0x85 acts exactly like 0x05.
- R6: When one 32-bit write carries both a clear and a set command for the same vector, the clear is applied first and the set second. A bit named by both commands therefore ends up set.
- R7: The request vector reads as word 0x00 (channels 31:0) and word 0x04 (channels 63:32). The error vector reads as word 0x08 (channels 31:0) and word 0x0C (channels 63:32). A write with all four byte enables replaces the addressed word. A write to these words without all four byte enables is ignored.
- R8: A read of the command word 0x18, or of any unmapped word, returns zero. Read data appears on `bus_rdata_o` in the cycle after the read is accepted.
- R9: A write changes the enable outputs at the first clock edge after it is accepted. The outputs do not change before that edge.
- R10: A command byte lane whose byte enable is low has no effect. A command issued as a read has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Access accepted this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address, word aligned |
| bus_be_i | input | 4 | Byte enables, lane k = address offset k |
| bus_wdata_i | input | 32 | Write data, lane k in bits 8k+7:8k |
| bus_rdata_o | output | 32 | Registered read data |
| req_en_o | output | 64 | Request enable per channel |
| err_en_o | output | 64 | Error-interrupt enable per channel |

## Verification
The vector assertions assume that a full-word write and a command never update the same vector in the same cycle. The address map makes this true, because the enable words and the command word are distinct addresses and only one access happens per cycle. The read-zero assertion assumes that the address is word aligned, and the stimulus only issues aligned addresses. The directed stimulus never leaves reset mid-run and holds the bus inputs stable between falling edges.

// File: rtl/chen_pkg.sv
package chen_pkg;
  localparam int unsigned CH_N   = 64;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CMD_W  = 7;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned WIDX_W = ADDR_W - 2;

  localparam logic [WIDX_W-1:0] W_REQ_LO = 6'h00;
  localparam logic [WIDX_W-1:0] W_REQ_HI = 6'h01;
  localparam logic [WIDX_W-1:0] W_ERR_LO = 6'h02;
  localparam logic [WIDX_W-1:0] W_ERR_HI = 6'h03;
  localparam logic [WIDX_W-1:0] W_CMD    = 6'h06;

  // byte lanes of the command word
  localparam int unsigned LN_CLR_REQ = 0;
  localparam int unsigned LN_SET_ERR = 1;
  localparam int unsigned LN_SET_REQ = 2;
  localparam int unsigned LN_CLR_ERR = 3;
endpackage

// File: rtl/chen_cmd_mask.sv
module chen_cmd_mask #(
  parameter int unsigned CMD_W = 7,
  parameter int unsigned CH_N  = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [7:0]      cmd_i,
  output logic [CH_N-1:0] mask_o
);
  localparam int unsigned SEL_W = CMD_W - 1;

  logic [SEL_W-1:0] sel;
  logic             all_ch;

  assign sel    = cmd_i[SEL_W-1:0];
  assign all_ch = cmd_i[CMD_W-1];  // bit 7 unused

  for (genvar i = 0; i < CH_N; i++) begin : g_bit
    assign mask_o[i] = valid_i & (all_ch | (sel == SEL_W'(i)));
  end

  assert_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cmd_i[CMD_W-1]) |-> (mask_o == {CH_N{1'b1}}));
  assert_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cmd_i[CMD_W-1]) |-> ($countones(mask_o) == 1));
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (mask_o == '0));
endmodule

// File: rtl/chen_enable_vec.sv
module chen_enable_vec #(
  parameter int unsigned CH_N   = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CH_N/WORD_W-1:0] wr_word_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [CH_N-1:0]   clr_mask_i,
  input  logic [CH_N-1:0]   set_mask_i,
  output logic [CH_N-1:0]   vec_o
);
  localparam int unsigned NW = CH_N / WORD_W;

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [WORD_W-1:0] cur, base, nxt;
    assign cur  = vec_o[w*WORD_W +: WORD_W];
    assign base = wr_word_i[w] ? wdata_i : cur;
    // clear first, then set
    assign nxt  = (base & ~clr_mask_i[w*WORD_W +: WORD_W]) | set_mask_i[w*WORD_W +: WORD_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vec_o[w*WORD_W +: WORD_W] <= '0;
      else         vec_o[w*WORD_W +: WORD_W] <= nxt;
    end
  end

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_mask_i != '0) |=> ((vec_o & $past(set_mask_i)) == $past(set_mask_i)));
  assert_clr_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_mask_i != '0) && (set_mask_i == '0) && (wr_word_i == '0))
      |=> ((vec_o & $past(clr_mask_i)) == '0));
  assert_others_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_word_i == '0)
      |=> ((vec_o & ~$past(clr_mask_i | set_mask_i)) == ($past(vec_o) & ~$past(clr_mask_i | set_mask_i))));
  assert_idle_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_word_i == '0) && (clr_mask_i == '0) && (set_mask_i == '0)) |=> $stable(vec_o));
endmodule

// File: rtl/chen_top.sv
module chen_top
  import chen_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_valid_i,
  input  logic               bus_write_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [3:0]         bus_be_i,
  input  logic [WORD_W-1:0]  bus_wdata_i,
  output logic [WORD_W-1:0]  bus_rdata_o,
  output logic [CH_N-1:0]    req_en_o,
  output logic [CH_N-1:0]    err_en_o
);
  localparam int unsigned NW = CH_N / WORD_W;

  logic [WIDX_W-1:0] widx;
  logic              wr, rd, wr_full, cmd_wr;
  logic [3:0]        lane_v;
  logic [CH_N-1:0]   lane_mask [4];
  logic [NW-1:0]     req_wr, err_wr;
  logic [WORD_W-1:0] rd_mux;

  assign widx    = bus_addr_i[ADDR_W-1:2];
  assign wr      = bus_valid_i & bus_write_i;
  assign rd      = bus_valid_i & ~bus_write_i;
  assign wr_full = wr & (bus_be_i == 4'hF);
  assign cmd_wr  = wr & (widx == W_CMD);

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_v[k] = cmd_wr & bus_be_i[k];
    chen_cmd_mask #(.CMD_W(CMD_W), .CH_N(CH_N)) u_mask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(lane_v[k]),
      .cmd_i  (bus_wdata_i[8*k +: 8]),
      .mask_o (lane_mask[k])
    );
  end

  assign req_wr = {wr_full & (widx == W_REQ_HI), wr_full & (widx == W_REQ_LO)};
  assign err_wr = {wr_full & (widx == W_ERR_HI), wr_full & (widx == W_ERR_LO)};

  chen_enable_vec #(.CH_N(CH_N), .WORD_W(WORD_W)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_word_i (req_wr),
    .wdata_i   (bus_wdata_i),
    .clr_mask_i(lane_mask[LN_CLR_REQ]),
    .set_mask_i(lane_mask[LN_SET_REQ]),
    .vec_o     (req_en_o)
  );

  chen_enable_vec #(.CH_N(CH_N), .WORD_W(WORD_W)) u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_word_i (err_wr),
    .wdata_i   (bus_wdata_i),
    .clr_mask_i(lane_mask[LN_CLR_ERR]),
    .set_mask_i(lane_mask[LN_SET_ERR]),
    .vec_o     (err_en_o)
  );

  always_comb begin
    unique case (widx)
      W_REQ_LO: rd_mux = req_en_o[WORD_W-1:0];
      W_REQ_HI: rd_mux = req_en_o[CH_N-1:WORD_W];
      W_ERR_LO: rd_mux = err_en_o[WORD_W-1:0];
      W_ERR_HI: rd_mux = err_en_o[CH_N-1:WORD_W];
      default:  rd_mux = '0;  // command word and holes read zero
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  bus_rdata_o <= '0;
    else if (rd)  bus_rdata_o <= rd_mux;
    else          bus_rdata_o <= '0;
  end

  assert_cmd_read_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (widx == W_CMD)) |=> (bus_rdata_o == '0));
  assert_read_lo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (widx == W_REQ_LO)) |=> (bus_rdata_o == $past(req_en_o[WORD_W-1:0])));
  assert_no_rd_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> ($stable(req_en_o) && $stable(err_en_o)));
endmodule

// File: tb/tb_chen_top.sv
module tb_chen_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid_i = 1'b0;
  logic        bus_write_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [3:0]  bus_be_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [63:0] req_en_o, err_en_o;

  int errors = 0;
  int checks = 0;
  logic [63:0] exp_req = '0, exp_err = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  chen_top dut (.*);

  task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(string tag);
    chk64({tag, " req"}, req_en_o, exp_req);
    chk64({tag, " err"}, err_en_o, exp_err);
  endtask

  // bench model of one command byte
  function automatic logic [63:0] cmask(logic [7:0] c);
    if (c[6]) return '1;
    return 64'd1 << c[5:0];
  endfunction

  task automatic bus_wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk_i);
    bus_valid_i = 1; bus_write_i = 1; bus_addr_i = a; bus_be_i = be; bus_wdata_i = d;
    @(negedge clk_i);
    bus_valid_i = 0; bus_write_i = 0; bus_be_i = '0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_valid_i = 1; bus_write_i = 0; bus_addr_i = a; bus_be_i = 4'hF;
    @(negedge clk_i);
    bus_valid_i = 0;
    d = bus_rdata_o;
  endtask

  // lanes: 0 clr_req, 1 set_err, 2 set_req, 3 clr_err
  task automatic cmd(logic [3:0] be, logic [7:0] cr, logic [7:0] se, logic [7:0] sr, logic [7:0] ce);
    bus_wr(8'h18, be, {ce, sr, se, cr});
    if (be[0]) exp_req &= ~cmask(cr);
    if (be[3]) exp_err &= ~cmask(ce);
    if (be[2]) exp_req |= cmask(sr);
    if (be[1]) exp_err |= cmask(se);
  endtask

  task automatic t_reset;
    chk_outs("R1 reset");
    chk64("R1 rdata", {32'd0, bus_rdata_o}, 64'd0);
  endtask

  task automatic t_single;
    cmd(4'b0100, 0, 0, 8'd5, 0);       chk_outs("R2 set req ch5");
    cmd(4'b0100, 0, 0, 8'd40, 0);      chk_outs("R2 set req ch40 hi word");
    cmd(4'b0010, 0, 8'd63, 0, 0);      chk_outs("R2 set err ch63");
    cmd(4'b0001, 8'd5, 0, 0, 0);       chk_outs("R3 clr req ch5");
    cmd(4'b1000, 0, 0, 0, 8'd63);      chk_outs("R3 clr err ch63");
  endtask

  task automatic t_all;
    cmd(4'b0100, 0, 0, 8'd64, 0);      chk_outs("R4 set all req 64");
    cmd(4'b0010, 0, 8'd127, 0, 0);     chk_outs("R4 set all err 127");
    cmd(4'b0001, 8'd100, 0, 0, 0);     chk_outs("R4 clr all req 100");
    cmd(4'b0100, 0, 0, 8'h85, 0);      chk_outs("R5 bit7 ignored set 0x85");
    cmd(4'b1000, 0, 0, 0, 8'hC0);      chk_outs("R5 bit7 ignored clr-all 0xC0");
  endtask

  task automatic t_order;
    cmd(4'b0101, 8'd7, 0, 8'd7, 0);    chk_outs("R6 clr+set same bit");
    cmd(4'b1111, 8'd64, 8'd33, 8'd12, 8'd64); chk_outs("R6 clr-all then set one");
  endtask

  task automatic t_timing;
    @(negedge clk_i);
    bus_valid_i = 1; bus_write_i = 1; bus_addr_i = 8'h18; bus_be_i = 4'b0100;
    bus_wdata_i = {8'd0, 8'd20, 8'd0, 8'd0};
    #1;
    chk_outs("R9 no change before edge");
    @(negedge clk_i);
    bus_valid_i = 0; bus_write_i = 0; bus_be_i = '0;
    exp_req |= 64'd1 << 20;
    chk_outs("R9 change after edge");
  endtask

  task automatic t_words;
    logic [31:0] d;
    bus_wr(8'h00, 4'hF, 32'hA5A5_0F0F); exp_req[31:0] = 32'hA5A5_0F0F;
    bus_wr(8'h0C, 4'hF, 32'h1234_5678); exp_err[63:32] = 32'h1234_5678;
    chk_outs("R7 full-word write");
    bus_wr(8'h04, 4'h3, 32'hFFFF_FFFF);
    chk_outs("R7 partial write ignored");
    bus_rd(8'h00, d); chk64("R7 read req lo", {32'd0, d}, {32'd0, exp_req[31:0]});
    bus_rd(8'h04, d); chk64("R7 read req hi", {32'd0, d}, {32'd0, exp_req[63:32]});
    bus_rd(8'h08, d); chk64("R7 read err lo", {32'd0, d}, {32'd0, exp_err[31:0]});
    bus_rd(8'h0C, d); chk64("R7 read err hi", {32'd0, d}, {32'd0, exp_err[63:32]});
    bus_rd(8'h18, d); chk64("R8 cmd read zero", {32'd0, d}, 64'd0);
    bus_rd(8'h2C, d); chk64("R8 hole read zero", {32'd0, d}, 64'd0);
    chk_outs("R10 read of cmd word no effect");
  endtask

  task automatic t_lanes;
    bus_wr(8'h18, 4'b0000, {8'd64, 8'd64, 8'd64, 8'd64});
    chk_outs("R10 no byte enables");
    cmd(4'b0100, 8'd64, 0, 8'd9, 8'd64);
    chk_outs("R10 only set lane enabled");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single();
    t_all();
    t_order();
    t_timing();
    t_words();
    t_lanes();
    repeat (2) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule